// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block sits between a clocked request port and an external asynchronous static RAM of 512K bytes. The RAM has one shared data bus and three active-low strobes: chip select, write strobe and output gate. A user issues a single-cycle request with a direction bit, a 19-bit address and a data byte. The controller then produces the strobe sequence the RAM needs. It returns a one-cycle completion pulse and, for reads, the captured byte.

The RAM has no clock, so every minimum pulse width, setup time, access time and bus release time is converted into a whole number of controller clock cycles. The conversion uses ceiling division of the nanosecond figure by the clock-period parameter, and no phase is shorter than one cycle. The RAM bus is split here into an output byte, an output-enable and an input byte, and the pad ring joins them into the tri-state pins. Between accesses the chip select is released, so the RAM sits in standby.

The default figures are: 55 ns cycle time, 45 ns write strobe and address-to-write-end, 25 ns data-to-write-end, 55 ns address access, 25 ns output-gate access and 20 ns bus release. With the default 5 ns clock these give a 9-cycle write strobe, an 11-cycle write, an 11-cycle read and a 4-cycle bus turnaround.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset, chip select, write strobe and output gate are all high (inactive), the data driver is off, and busy and done are both low.
- R2: A write holds chip select and write strobe low together for exactly N_WP cycles (9 at defaults), keeps the output gate high for the whole write, and drives the write byte on the bus for the entire strobe.
- R3: While chip select and write strobe are both low, neither the RAM address nor the driven data byte changes.
- R4: A write completes with done exactly 11 cycles (at defaults) after the accepting clock edge, covering the 55 ns cycle time, and the RAM then holds the written byte at that address.
- R5: A read holds chip select and output gate low with write strobe high and the driver off for 11 cycles (at defaults). It then captures the bus into rdata_o at the edge that raises done, with no later edge involved.
- R6: After a read releases the output gate, the data driver stays off until at least N_TURN (4 at defaults) clock edges have passed. A write requested sooner is delayed by the missing cycles.
- R7: busy is high from the accepting edge until done rises. busy is low in the done cycle. Requests that arrive while busy is high are ignored.
- R8: done is a single-cycle pulse, one per accepted request. rdata_o keeps the last read byte until the next read completes.
- R9: The data driver is never enabled while the output gate is low.
- R10: Chip select is high whenever no access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe, sampled when not busy |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 19 | Byte address |
| wdata_i | input | 8 | Write byte |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Last captured read byte |
| sram_addr_o | output | 19 | RAM address lines |
| sram_dq_o | output | 8 | Byte driven onto the RAM bus |
| sram_dq_oe_o | output | 1 | Enable of the bus driver |
| sram_dq_i | input | 8 | Byte sampled from the RAM bus |
| sram_ce_n_o | output | 1 | RAM chip select, active low |
| sram_we_n_o | output | 1 | RAM write strobe, active low |
| sram_oe_n_o | output | 1 | RAM output gate, active low |

## Verification
The bound checker tests the following on every cycle:
- the driver is never on while the output gate is low;
- the output gate is high whenever the write strobe is low;
- the address and data are stable during the write overlap;
- the write strobe is exactly N_WP cycles long;
- the driver waits at least N_TURN cycles after the output gate rises;
- done is a single-cycle pulse that never coincides with busy.

Only the bench scenarios can show three further points. The RAM model returns valid data only after the full access time, so a read sampled too early is caught. The bus model shows whether written bytes really land in memory and read back. The bench also confirms that requests injected while busy leave memory and completion counts untouched.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WTURN,
        ST_WPULSE,
        ST_WREC,
        ST_RACC
    } st_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // cycles covering a nanosecond minimum, never fewer than one
    function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned per);
        return max2(1, (ns + per - 1) / per);
    endfunction

endpackage

// File: rtl/sram_turn_guard.sv
`timescale 1ns/1ps
module sram_turn_guard #(
    parameter int unsigned N_TURN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic ready_o
);
    localparam int TW = $clog2(N_TURN + 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = TW'(N_TURN);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // one count left means the driver may switch on at the coming edge
    assign ready_o = (cnt_q <= TW'(1));
endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic [DATA_W-1:0] bus_i,
    output logic [DATA_W-1:0] data_o
);
    logic [DATA_W-1:0] data_d, data_q;

    always_comb begin
        data_d = cap_i ? bus_i : data_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign data_o = data_q;
endmodule

// File: rtl/sram_strobe_ctrl.sv
`timescale 1ns/1ps
module sram_strobe_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int          ADDR_W    = 19,
    parameter int          DATA_W    = 8,
    parameter int unsigned CLK_NS    = 5,
    parameter int unsigned T_CYC_NS  = 55,
    parameter int unsigned T_WLOW_NS = 45,
    parameter int unsigned T_AW_NS   = 45,
    parameter int unsigned T_DW_NS   = 25,
    parameter int unsigned T_AACC_NS = 55,
    parameter int unsigned T_OACC_NS = 25,
    parameter int unsigned T_REL_NS  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [ADDR_W-1:0] sram_addr_o,
    output logic [DATA_W-1:0] sram_dq_o,
    output logic              sram_dq_oe_o,
    input  logic [DATA_W-1:0] sram_dq_i,
    output logic              sram_ce_n_o,
    output logic              sram_we_n_o,
    output logic              sram_oe_n_o
);
    // address and data are applied at strobe start, so their setup equals the strobe
    localparam int unsigned N_WP    = max2(ns2cyc(T_WLOW_NS, CLK_NS),
                                           max2(ns2cyc(T_AW_NS, CLK_NS), ns2cyc(T_DW_NS, CLK_NS)));
    localparam int unsigned N_WC    = ns2cyc(T_CYC_NS, CLK_NS);
    localparam int unsigned N_WREC  = (N_WC > N_WP) ? (N_WC - N_WP) : 1;
    localparam int unsigned N_RD    = max2(N_WC, max2(ns2cyc(T_AACC_NS, CLK_NS), ns2cyc(T_OACC_NS, CLK_NS)));
    localparam int unsigned N_TURN  = ns2cyc(T_REL_NS, CLK_NS);
    localparam int unsigned CNT_MAX = max2(N_WP, max2(N_WREC, N_RD));
    localparam int          CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        st_e               st;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              ce_n;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
        logic              busy;
        logic              done;
    } regs_t;

    localparam regs_t RESET_VAL = '{
        st: ST_IDLE, cnt: '0, addr: '0, wdata: '0,
        ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0,
        busy: 1'b0, done: 1'b0
    };

    regs_t r_d, r_q;
    logic  turn_ok;
    logic  rd_end;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        rd_end   = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_i) begin
                    r_d.busy  = 1'b1;
                    r_d.addr  = addr_i;
                    r_d.wdata = wdata_i;
                    if (we_i) begin
                        if (turn_ok) begin
                            r_d.st    = ST_WPULSE;
                            r_d.ce_n  = 1'b0;
                            r_d.we_n  = 1'b0;
                            r_d.dq_oe = 1'b1;
                            r_d.cnt   = CNT_W'(N_WP - 1);
                        end else begin
                            r_d.st = ST_WTURN;
                        end
                    end else begin
                        r_d.st   = ST_RACC;
                        r_d.ce_n = 1'b0;
                        r_d.oe_n = 1'b0;
                        r_d.cnt  = CNT_W'(N_RD - 1);
                    end
                end
            end
            ST_WTURN: begin
                if (turn_ok) begin
                    r_d.st    = ST_WPULSE;
                    r_d.ce_n  = 1'b0;
                    r_d.we_n  = 1'b0;
                    r_d.dq_oe = 1'b1;
                    r_d.cnt   = CNT_W'(N_WP - 1);
                end
            end
            ST_WPULSE: begin
                if (r_q.cnt == '0) begin
                    r_d.st   = ST_WREC;
                    r_d.ce_n = 1'b1;
                    r_d.we_n = 1'b1;
                    r_d.cnt  = CNT_W'(N_WREC - 1);
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_WREC: begin
                if (r_q.cnt == '0) begin
                    r_d.st    = ST_IDLE;
                    r_d.dq_oe = 1'b0;
                    r_d.busy  = 1'b0;
                    r_d.done  = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_RACC: begin
                if (r_q.cnt == '0) begin
                    rd_end   = 1'b1;
                    r_d.st   = ST_IDLE;
                    r_d.ce_n = 1'b1;
                    r_d.oe_n = 1'b1;
                    r_d.busy = 1'b0;
                    r_d.done = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            default: r_d = RESET_VAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_VAL;
        else        r_q <= r_d;
    end

    sram_turn_guard #(.N_TURN(N_TURN)) u_turn (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (rd_end),
        .ready_o (turn_ok)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_i  (rd_end),
        .bus_i  (sram_dq_i),
        .data_o (rdata_o)
    );

    assign busy_o       = r_q.busy;
    assign done_o       = r_q.done;
    assign sram_addr_o  = r_q.addr;
    assign sram_dq_o    = r_q.wdata;
    assign sram_dq_oe_o = r_q.dq_oe;
    assign sram_ce_n_o  = r_q.ce_n;
    assign sram_we_n_o  = r_q.we_n;
    assign sram_oe_n_o  = r_q.oe_n;
endmodule

// File: rtl/sram_strobe_chk.sv
`timescale 1ns/1ps
module sram_strobe_chk #(
    parameter int          ADDR_W = 19,
    parameter int          DATA_W = 8,
    parameter int unsigned N_WP   = 9,
    parameter int unsigned N_TURN = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              we_n,
    input logic              oe_n,
    input logic              dq_oe,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] dq_o,
    input logic              busy,
    input logic              done
);
    logic [15:0] wlow_cnt;
    logic [15:0] oe_gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wlow_cnt <= '0;
            oe_gap   <= 16'(N_TURN);
        end else begin
            if (!we_n) wlow_cnt <= (wlow_cnt == 16'hFFFF) ? wlow_cnt : wlow_cnt + 1'b1;
            else       wlow_cnt <= '0;
            if (!oe_n)                    oe_gap <= '0;
            else if (oe_gap < 16'(N_TURN)) oe_gap <= oe_gap + 1'b1;
        end
    end

    a_r9_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> oe_n);

    a_r2_gate_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (oe_n && !ce_n && dq_oe));

    a_r3_addr_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !we_n) |=> (ce_n || we_n || ($stable(addr) && $stable(dq_o))));

    a_r2_strobe_length: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (wlow_cnt == 16'(N_WP)));

    a_r6_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> (oe_gap >= 16'(N_TURN)));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r10_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ce_n);
endmodule

bind sram_strobe_ctrl sram_strobe_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .N_WP   (N_WP),
    .N_TURN (N_TURN)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .ce_n  (sram_ce_n_o),
    .we_n  (sram_we_n_o),
    .oe_n  (sram_oe_n_o),
    .dq_oe (sram_dq_oe_o),
    .addr  (sram_addr_o),
    .dq_o  (sram_dq_o),
    .busy  (busy_o),
    .done  (done_o)
);

// File: tb/sram_strobe_ctrl_tb.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_tb;

    function automatic int cyc_of(input int ns);
        int c;
        c = (ns + 4) / 5;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int N_WP   = cyc_of(45);
    localparam int N_WC   = cyc_of(55);
    localparam int N_RD   = cyc_of(55);
    localparam int N_TURN = cyc_of(20);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [18:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        busy, done;
    logic [7:0]  rdata;
    logic [18:0] s_addr;
    logic [7:0]  s_dq_o;
    logic        s_dq_oe;
    logic [7:0]  s_dq_i = 8'hEE;
    logic        s_ce_n, s_we_n, s_oe_n;

    always #2.5 clk = ~clk;

    sram_strobe_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
        .wdata_i(wdata), .busy_o(busy), .done_o(done), .rdata_o(rdata),
        .sram_addr_o(s_addr), .sram_dq_o(s_dq_o), .sram_dq_oe_o(s_dq_oe),
        .sram_dq_i(s_dq_i), .sram_ce_n_o(s_ce_n), .sram_we_n_o(s_we_n),
        .sram_oe_n_o(s_oe_n)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit finished = 1'b0;

    logic [7:0] ram_mem [int];
    logic [7:0] ref_mem [int];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_rd(input logic [18:0] a);
        return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
    endfunction

    // RAM model: writes land on strobe end, reads valid only after full access time
    int          wl = 0, rl = 0, since_rel = 100;
    bit          wok = 1'b1;
    logic [18:0] wa, ra;
    logic [7:0]  wd;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!s_ce_n && !s_we_n) begin
                if (wl > 0 && (s_addr != wa || s_dq_o != wd))
                    chk(1'b0, "R3", "address/data moved during write overlap", int'(s_addr), int'(wa));
                wl++; wa = s_addr; wd = s_dq_o; wok = wok && s_dq_oe;
            end else if (wl > 0) begin
                ram_mem[int'(wa)] = (wl >= N_WP && wok) ? wd : 8'hBD;
                wl = 0; wok = 1'b1;
            end
            if (!s_ce_n && !s_oe_n && s_we_n) begin
                if (rl > 0 && s_addr != ra) rl = 0;
                rl++; ra = s_addr; since_rel = 0;
            end else begin
                rl = 0;
                if (since_rel < 100) since_rel++;
            end
            if (s_dq_oe && !s_oe_n)
                chk(1'b0, "R9", "driver on while output gate low", 1, 0);
            if (s_dq_oe && since_rel <= N_TURN)
                chk(1'b0, "R6", "driver on before turnaround", since_rel, N_TURN + 1);
            s_dq_i = (rl >= N_RD) ? (ram_mem.exists(int'(ra)) ? ram_mem[int'(ra)] : 8'h00) : 8'hEE;
        end
    end

    bit         last_rd = 1'b0;
    int         last_done = -100;
    logic [7:0] last_rdata = 8'h00;

    task automatic do_op(input bit w, input logic [18:0] a, input logic [7:0] d, input bit inject);
        int lat, g, extra;
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        g = cyc + 1 - last_done;
        extra = (w && last_rd && g < N_TURN) ? N_TURN - g : 0;
        @(negedge clk);
        req = 1'b0;
        chk(busy, "R7", "busy after accept", int'(busy), 1);
        lat = 0;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
            if (inject && lat == 3) begin
                req = 1'b1; we = ~w; addr = a ^ 19'h1; wdata = ~d;
            end else begin
                req = 1'b0;
            end
            if (!done && !busy) chk(1'b0, "R7", "busy dropped early", 0, 1);
        end
        req = 1'b0;
        chk(lat == (w ? N_WC : N_RD) + extra, w ? "R4" : "R5", "latency",
            lat, (w ? N_WC : N_RD) + extra);
        chk(!busy, "R7", "busy low in done cycle", int'(busy), 0);
        chk(s_ce_n, "R10", "deselected when done", int'(s_ce_n), 1);
        if (w) begin
            ref_mem[int'(a)] = d;
            chk(rdata == last_rdata, "R8", "rdata held across write", int'(rdata), int'(last_rdata));
        end else begin
            chk(rdata == ref_rd(a), "R5", "read data", int'(rdata), int'(ref_rd(a)));
            last_rdata = ref_rd(a);
        end
        last_rd = !w;
        last_done = cyc;
        @(negedge clk);
        chk(!done, "R8", "done is one cycle", int'(done), 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [18:0] pool [8];
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(s_ce_n && s_we_n && s_oe_n, "R1", "strobes inactive in reset",
            int'({s_ce_n, s_we_n, s_oe_n}), 7);
        chk(!s_dq_oe && !busy && !done, "R1", "driver/busy/done low in reset",
            int'({s_dq_oe, busy, done}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(s_ce_n, "R10", "idle deselect after reset", int'(s_ce_n), 1);

        // directed corners
        do_op(1'b1, 19'h00000, 8'hFF, 1'b0);               // R2 R4 lowest address
        do_op(1'b1, 19'h7FFFF, 8'h00, 1'b0);               // R2 R4 highest address
        do_op(1'b0, 19'h00000, 8'h00, 1'b0);               // R5
        do_op(1'b1, 19'h00001, 8'h5A, 1'b0);               // R6 write right after read
        do_op(1'b0, 19'h7FFFF, 8'h00, 1'b0);               // R5
        do_op(1'b1, 19'h00010, 8'hC3, 1'b1);               // R7 injected read-to-0x11 ignored
        do_op(1'b0, 19'h00011, 8'h00, 1'b1);               // R7 injected write-to-0x10 ignored
        do_op(1'b0, 19'h00010, 8'h00, 1'b0);               // R7 value untouched by inject
        do_op(1'b0, 19'h00001, 8'h00, 1'b0);               // R4 write after read landed

        for (int i = 0; i < 8; i++) pool[i] = 19'($urandom);
        pool[0] = 19'h00000; pool[1] = 19'h7FFFF;
        for (int i = 0; i < 80; i++) begin
            bit          w = 1'($urandom);
            logic [18:0] a = pool[$urandom % 8];
            int          gap = $urandom % 6;
            repeat (gap) @(negedge clk);
            do_op(w, a, 8'($urandom), ($urandom % 5) == 0);
        end
        for (int i = 0; i < 8; i++) do_op(1'b0, pool[i], 8'h00, 1'b0);
        finish_run();
    end
endmodule